// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block sits in the always-on part of a small microcontroller and decides which clock domains run while the core sleeps. A 3-bit mode field picks one of three sleep depths. A sleep strobe moves the controller into that depth, and it then drops the clock enables of the domains that the depth stops. The five gated domains are CPU, program memory, peripheral I/O, converter (ADC) and asynchronous timer.

While asleep, the controller watches a vector of wake-up requests. Only the requests that the current depth allows can end the sleep. When one of them arrives, every clock comes back at once. When the converter is enabled and the core enters one of the two shallow depths, the block also issues a one-cycle conversion-start pulse.

Top module: `sleep_clock_gate`

## Requirements
- R1: After reset all five clock enables are 1, `sleeping` is 0 and `adc_start` is 0.
- R2: A `sleep_req` with `mode_sel` = 0 (light sleep) sets `sleeping` at the next rising edge. At that edge it clears the CPU and memory enables and keeps the I/O, converter and asynchronous-timer enables at 1.
- R3: A `sleep_req` with `mode_sel` = 1 (converter-quiet sleep) sets `sleeping` at the next edge. At that edge it clears the CPU, memory and I/O enables and keeps the converter and asynchronous-timer enables at 1.
- R4: A `sleep_req` with `mode_sel` = 2 (deep sleep) sets `sleeping` at the next edge and clears all five enables.
- R5: A `sleep_req` with `mode_sel` from 3 to 7 is ignored. `sleeping` stays 0 and all enables stay 1.
- R6: `wake_req` bit positions have these meanings:
  - 0: external level interrupt
  - 1: pin change
  - 2: external reset
  - 3: watchdog
  - 4: brown-out reset
  - 5: serial address match
  - 6: asynchronous timer interrupt
  - 7: memory-ready interrupt
  - 8: conversion complete
  - 9: other timer interrupt
  - 10: other serial interrupt

  In light sleep, any of bits 0 to 10 wakes the block.
- R7: In converter-quiet sleep, only `wake_req` bits 0 to 8 wake the block. Bits 9 and 10 leave it asleep.
- R8: In deep sleep, only `wake_req` bits 0 to 5 wake the block. Bits 6 to 10 leave it asleep.
- R9: `adc_start` is high for exactly the one cycle after the entry edge. This happens only when `adc_enabled` was 1 at entry and the mode is 0 or 1.
- R10: An allowed wake request clears `sleeping` and sets all five enables to 1 at the same next edge. A `sleep_req` received while already asleep changes nothing.
- R11: The clock enables are registered and change only at the edges where `sleeping` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Sleep depth select (0 light, 1 converter-quiet, 2 deep, others reserved) |
| sleep_req | input | 1 | Sleep strobe |
| adc_enabled | input | 1 | Converter is enabled |
| wake_req | input | 11 | Wake-up requests, bit meanings in R6 |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_clk_en | output | 1 | Program memory clock enable |
| io_clk_en | output | 1 | Peripheral I/O clock enable |
| adc_clk_en | output | 1 | Converter clock enable |
| async_clk_en | output | 1 | Asynchronous timer clock enable |
| adc_start | output | 1 | One-cycle conversion start pulse |
| sleeping | output | 1 | Core is asleep |

## Verification
The bench sweeps all eight mode codes with the converter both enabled and disabled. A design that decoded a reserved code as a sleep depth would drop clocks that must stay on. A design that started a conversion on entry to deep sleep would raise a pulse that must stay low.

Every wake bit is then applied on its own in each of the three depths. A mask off by one bit would either leave the core asleep on a legal event or wake it on a filtered one.

The bench also sends a second sleep strobe while the block is asleep. A design that re-latched the mode on that strobe would change the gating pattern mid-sleep.

// File: rtl/sleep_clock_gate.sv
module sleep_clock_gate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  mode_sel,
  input  logic        sleep_req,
  input  logic        adc_enabled,
  input  logic [10:0] wake_req,
  output logic        cpu_clk_en,
  output logic        flash_clk_en,
  output logic        io_clk_en,
  output logic        adc_clk_en,
  output logic        async_clk_en,
  output logic        adc_start,
  output logic        sleeping
);
  localparam logic [2:0] M_LIGHT = 3'd0;
  localparam logic [2:0] M_QUIET = 3'd1;
  localparam logic [2:0] M_DEEP  = 3'd2;
  localparam logic [4:0] EN_ALL  = 5'b11111;

  logic        sleeping_q;
  logic [2:0]  mode_q;
  logic [4:0]  en_q;
  logic        start_q;
  logic [10:0] allow;
  logic [4:0]  gate_pat;
  logic        enter, wake;

  always_comb begin
    case (mode_q)
      M_LIGHT: allow = 11'h7FF;
      M_QUIET: allow = 11'h1FF;
      M_DEEP:  allow = 11'h03F;
      default: allow = 11'h000;
    endcase
  end

  always_comb begin
    case (mode_sel)
      M_LIGHT: gate_pat = 5'b11100;
      M_QUIET: gate_pat = 5'b11000;
      default: gate_pat = 5'b00000;
    endcase
  end

  assign enter = sleep_req && !sleeping_q && (mode_sel <= M_DEEP);
  assign wake  = sleeping_q && |(wake_req & allow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleeping_q <= 1'b0;
      mode_q     <= M_LIGHT;
      en_q       <= EN_ALL;
      start_q    <= 1'b0;
    end else begin
      start_q <= enter && adc_enabled && (mode_sel != M_DEEP);
      if (enter) begin
        sleeping_q <= 1'b1;
        mode_q     <= mode_sel;
        en_q       <= gate_pat;
      end else if (wake) begin
        sleeping_q <= 1'b0;
        en_q       <= EN_ALL;
      end
    end
  end

  assign {async_clk_en, adc_clk_en, io_clk_en, flash_clk_en, cpu_clk_en} = en_q;
  assign adc_start = start_q;
  assign sleeping  = sleeping_q;

  AST_RESERVED_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping && sleep_req && mode_sel > M_DEEP) |=> !sleeping); // R5
  AST_WAKE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleeping) |-> (cpu_clk_en && flash_clk_en && io_clk_en && adc_clk_en && async_clk_en)); // R10
  AST_NO_WAKE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && wake_req == 11'd0) |=> sleeping); // R10
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start); // R9
  AST_START_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> ($rose(sleeping) && adc_clk_en)); // R9
  AST_CORE_OFF_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |-> (!cpu_clk_en && !flash_clk_en)); // R2
  AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(sleeping) |-> $stable({async_clk_en, adc_clk_en, io_clk_en, flash_clk_en, cpu_clk_en})); // R11
endmodule

// File: tb/sleep_clock_gate_bench.sv
`timescale 1ns/1ps
module sleep_clock_gate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic sleep_req = 1'b0;
  logic adc_enabled = 1'b0;
  logic [10:0] wake_req = 11'd0;
  logic cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, async_clk_en, adc_start, sleeping;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sleep_clock_gate u_sleep_clock_gate (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_req(sleep_req),
    .adc_enabled(adc_enabled), .wake_req(wake_req),
    .cpu_clk_en(cpu_clk_en), .flash_clk_en(flash_clk_en), .io_clk_en(io_clk_en),
    .adc_clk_en(adc_clk_en), .async_clk_en(async_clk_en),
    .adc_start(adc_start), .sleeping(sleeping));

  function automatic logic [4:0] en_vec();
    return {async_clk_en, adc_clk_en, io_clk_en, flash_clk_en, cpu_clk_en};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_gate(input int m);
    if (m > 2) return 5'b11111;
    return {1'(m < 2), 1'(m < 2), 1'(m == 0), 2'b00};
  endfunction

  function automatic bit exp_wakes(input int m, input int b);
    int lim = (m == 0) ? 11 : (m == 1) ? 9 : 6;
    return b < lim;
  endfunction

  task automatic enter(input int m, input bit adc);
    mode_sel = 3'(m); adc_enabled = adc; sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic force_wake();
    wake_req = 11'd1;
    @(negedge clk);
    wake_req = 11'd0;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 enables", en_vec(), 5'h1f);
    chk("R1 sleeping", sleeping, 0);
    chk("R1 adc_start", adc_start, 0);

    for (int m = 0; m < 8; m++) begin
      for (int a = 0; a < 2; a++) begin
        enter(m, a[0]);
        if (m == 0) chk("R2 gating", en_vec(), exp_gate(m));
        else if (m == 1) chk("R3 gating", en_vec(), exp_gate(m));
        else if (m == 2) chk("R4 gating", en_vec(), exp_gate(m));
        else chk("R5 reserved enables", en_vec(), exp_gate(m));
        chk(m > 2 ? "R5 reserved sleeping" : "R2 R3 R4 sleeping", sleeping, m <= 2);
        chk("R9 start pulse", adc_start, (a == 1) && (m < 2));
        @(negedge clk);
        chk("R9 pulse length", adc_start, 0);
        if (m <= 2) begin
          force_wake();
          chk("R10 restore", en_vec(), 5'h1f);
          chk("R10 awake", sleeping, 0);
        end
      end
    end

    for (int m = 0; m < 3; m++) begin
      for (int b = 0; b < 11; b++) begin
        enter(m, 1'b0);
        wake_req = 11'(1 << b);
        @(negedge clk);
        wake_req = 11'd0;
        if (m == 0) chk("R6 light wake", !sleeping, exp_wakes(m, b));
        else if (m == 1) chk("R7 quiet wake", !sleeping, exp_wakes(m, b));
        else chk("R8 deep wake", !sleeping, exp_wakes(m, b));
        if (sleeping) begin
          chk("R11 enables held", en_vec(), exp_gate(m));
          force_wake();
        end else begin
          chk("R10 wake restores", en_vec(), 5'h1f);
        end
      end
    end

    enter(2, 1'b1);
    mode_sel = 3'd0; adc_enabled = 1'b1; sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk("R10 resleep ignored enables", en_vec(), 5'h00);
    chk("R10 resleep no pulse", adc_start, 0);
    wake_req = 11'h400;
    @(negedge clk);
    wake_req = 11'd0;
    chk("R8 bit10 filtered in deep", sleeping, 1);
    force_wake();
    chk("R10 final restore", en_vec(), 5'h1f);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule